// File: doc/BRIEF.md
# Block-Transfer Serial Configuration Slave

This block is a two-wire serial slave that lets a clock generator's configuration be loaded and read back over a slow shared bus. It holds eight byte-wide registers and presents all of them at once as a flat vector to the rest of the clock logic. The slave accepts block transfers only. There is no register pointer. Every write fills registers in order from byte 0. Every read returns a byte count and then the whole bank.

Both bus lines are sampled into the system clock domain through two-flop synchronizers. Start and stop conditions are recognised from SDA edges while SCL is high. Data bits are taken on SCL rising edges. The slave changes SDA only after SCL has fallen. SDA is open-drain: the block never drives it high. It only raises an enable that pulls the line low, and the pad and pull-up sit outside the block.

Top module: `cfg_serial_slave`

## Requirements
- R1: A start followed by address byte 0xD2 (write) or 0xD3 (read) is acknowledged: the slave holds SDA low during the ninth SCL pulse of that byte.
- R2: Any other address byte is not acknowledged. The slave then leaves SDA released and ignores the bus until the next start, and no register changes.
- R3: In a write, the two bytes after the address (command code, then byte count) are each acknowledged and have no effect on any register.
- R4: Data bytes of a write are stored in order, the k-th data byte into register k, starting at register 0. Register n appears on cfg_bank_o bits 8n+7:8n. Bits arrive MSB first, and each data byte is acknowledged.
- R5: A stop after any complete byte ends the write. Registers already written keep their new values and the others keep their old ones.
- R6: Data bytes aimed at register 7 or beyond are acknowledged but change nothing. Register 7 is read-only and holds the top byte of the reset image (0x00 by default).
- R7: A read sends the byte count 0x08 and then registers 0 through 7, each MSB first, moving on after every byte the master acknowledges.
- R8: A master NACK during a read ends the read. The slave releases SDA and stays released until the next start.
- R9: After reset the registers read 0x00, 0xFF, 0xFF, 0x7F, 0xFF, 0xFF, 0x07, 0x00 for bytes 0 to 7, and SDA is released.
- R10: Every new write transfer starts again at register 0, whatever the length of the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 leaves it to the pull-up |
| cfg_bank_o | output | 64 | All registers, register n in bits 8n+7:8n |

## Verification
The assertions assume a master that moves SDA only while SCL is low, except to form a start or a stop. They also assume that each SCL level lasts longer than the synchronizer latency, so the engine sees every edge in order and never sees a start or stop in the middle of a bit. The bench master holds every quarter bit period for ten system clocks and changes data one quarter after SCL falls. This keeps the data-valid window well clear of the three-cycle input delay. Random write lengths run past the writable range and random read cut-off points are mixed with directed cases: a wrong address, a zero-length write, and NACK on the count byte.

// File: rtl/cfgs_pkg.sv
// Shared types for the serial configuration slave.
// Assumes nothing beyond IEEE 1800-2017 enums.
package cfgs_pkg;

    // Engine phase: receiving a byte, its acknowledge, sending, or the master's acknowledge
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_RX     = 3'd1,
        PH_RX_ACK = 3'd2,
        PH_TX     = 3'd3,
        PH_TX_ACK = 3'd4
    } phase_t;

    // Meaning of the byte being received in a write transfer
    typedef enum logic [1:0] {
        RX_ADDR = 2'd0,
        RX_CMD  = 2'd1,
        RX_CNT  = 2'd2,
        RX_DATA = 2'd3
    } rx_stage_t;

endpackage

// File: rtl/cfgs_line_sync.sv
// Brings SCL and SDA into the system clock domain and derives bus events.
// Assumes: each SCL level lasts well over three system clocks; glitch
// filtering is done elsewhere. Events are single-cycle pulses.
module cfgs_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_q;
    logic       sda_q;

    // Two-flop synchronizers plus one history flop per line; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    // Edge and condition decode on the synchronized lines
    always_comb begin
        sda_s    = sda_ff[1];
        scl_rise = scl_ff[1] & ~scl_q;
        scl_fall = ~scl_ff[1] & scl_q;
        start_ev = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
        stop_ev  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
    end

endmodule

// File: rtl/cfgs_bank.sv
// Configuration register bank: all but the last register are writable,
// the last one is a constant taken from the reset image.
// Assumes one write strobe per cycle at most, with address below NUM_REGS-1.
module cfgs_bank #(
    parameter int                      NUM_REGS    = 8,
    parameter logic [8*NUM_REGS-1:0]   RESET_IMAGE = 64'h00_07_FF_FF_7F_FF_FF_00,
    localparam int                     IDX_W       = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [IDX_W-1:0]        rd_addr,
    output logic [7:0]              rd_data,
    output logic [8*NUM_REGS-1:0]   bank_o
);
    logic [7:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g < NUM_REGS - 1) begin : g_rw
            // Writable register, loaded from the engine's strobe
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= RESET_IMAGE[8*g +: 8];
                else if (wr_en && wr_addr == IDX_W'(g))
                    regs[g] <= wr_data;
            end
        end else begin : g_ro
            // Read-only register fixed at its reset image
            assign regs[g] = RESET_IMAGE[8*g +: 8];
        end
        assign bank_o[8*g +: 8] = regs[g];
    end

    // Read port used by the transmit path
    always_comb rd_data = regs[rd_addr];

endmodule

// File: rtl/cfgs_engine.sv
// Byte-level protocol engine of the serial slave. Decodes the address,
// discards command and count bytes, issues write strobes in order from
// register 0, and sends the count byte and the bank on a read.
// Assumes synchronized bus events from cfgs_line_sync.
module cfgs_engine
    import cfgs_pkg::*;
#(
    parameter int          NUM_REGS   = 8,
    parameter logic [6:0]  SLAVE_ADDR = 7'h69,
    localparam int         IDX_W      = $clog2(NUM_REGS),
    localparam int         CNT_W      = $clog2(NUM_REGS + 1),
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS),
    localparam logic [CNT_W-1:0] WR_LIMIT = CNT_W'(NUM_REGS - 1),
    localparam logic [CNT_W-1:0] WR_SAT   = CNT_W'(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_addr,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             sda_oe,
    output phase_t           phase
);
    rx_stage_t        stage;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [CNT_W-1:0] wr_idx;
    logic [CNT_W-1:0] tx_idx;
    logic             is_read;
    logic             m_ack;

    // Register to read next is the one after the last byte sent
    always_comb rd_addr = tx_idx[IDX_W-1:0];

    // Protocol state machine, advanced only on synchronized bus events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            stage   <= RX_ADDR;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            wr_idx  <= '0;
            tx_idx  <= '0;
            is_read <= 1'b0;
            m_ack   <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                phase   <= PH_RX;
                stage   <= RX_ADDR;
                bit_cnt <= '0;
                wr_idx  <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RX: begin
                        if (scl_rise && bit_cnt != 4'd8) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (stage == RX_ADDR) begin
                                if (rx_sh[7:1] == SLAVE_ADDR) begin
                                    is_read <= rx_sh[0];
                                    sda_oe  <= 1'b1;
                                    phase   <= PH_RX_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                phase  <= PH_RX_ACK;
                                if (stage == RX_DATA) begin
                                    wr_en   <= (wr_idx < WR_LIMIT);
                                    wr_addr <= wr_idx[IDX_W-1:0];
                                    wr_data <= rx_sh;
                                    if (wr_idx != WR_SAT)
                                        wr_idx <= wr_idx + 1'b1;
                                end
                            end
                        end
                    end
                    PH_RX_ACK: begin
                        if (scl_fall) begin
                            if (stage == RX_ADDR && is_read) begin
                                sda_oe  <= ~COUNT_BYTE[7];
                                tx_sh   <= {COUNT_BYTE[6:0], 1'b0};
                                bit_cnt <= 4'd1;
                                tx_idx  <= '0;
                                phase   <= PH_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RX;
                                unique case (stage)
                                    RX_ADDR: stage <= RX_CMD;
                                    RX_CMD:  stage <= RX_CNT;
                                    default: stage <= RX_DATA;
                                endcase
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_TX_ACK;
                            end else begin
                                sda_oe  <= ~tx_sh[7];
                                tx_sh   <= {tx_sh[6:0], 1'b0};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (m_ack && tx_idx < WR_SAT) begin
                                sda_oe  <= ~rd_data[7];
                                tx_sh   <= {rd_data[6:0], 1'b0};
                                bit_cnt <= 4'd1;
                                tx_idx  <= tx_idx + 1'b1;
                                phase   <= PH_TX;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_serial_slave.sv
// Top of the serial configuration slave: input synchronizer, protocol
// engine and register bank. SDA is split into a sensed input and a
// pull-low enable; the open-drain pad is outside this block.
module cfg_serial_slave
    import cfgs_pkg::*;
#(
    parameter int                    NUM_REGS    = 8,
    parameter logic [6:0]            SLAVE_ADDR  = 7'h69,
    parameter logic [8*NUM_REGS-1:0] RESET_IMAGE = 64'h00_07_FF_FF_7F_FF_FF_00,
    localparam int                   IDX_W       = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [8*NUM_REGS-1:0] cfg_bank_o
);
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_ev;
    logic             stop_ev;
    logic [7:0]       rd_data;
    logic [IDX_W-1:0] rd_addr;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic             sda_oe;
    phase_t           phase;

    cfgs_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    cfgs_engine #(
        .NUM_REGS   (NUM_REGS),
        .SLAVE_ADDR (SLAVE_ADDR)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe),
        .phase    (phase)
    );

    cfgs_bank #(
        .NUM_REGS    (NUM_REGS),
        .RESET_IMAGE (RESET_IMAGE)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .bank_o  (cfg_bank_o)
    );

    // Pull-low enable goes straight from the engine's flop to the pad
    assign sda_oe_o = sda_oe;

endmodule

// File: rtl/cfgs_checker.sv
// Property checker for cfg_serial_slave, attached by bind below.
// Assumes a well-formed bus master (see the brief).
module cfgs_checker
    import cfgs_pkg::*;
#(
    parameter int                    NUM_REGS    = 8,
    parameter logic [8*NUM_REGS-1:0] RESET_IMAGE = 64'h00_07_FF_FF_7F_FF_FF_00,
    localparam int                   IDX_W       = $clog2(NUM_REGS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_oe,
    input logic [8*NUM_REGS-1:0] cfg_bank,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      wr_addr,
    input phase_t                phase
);
    // R9: the first cycle out of reset shows the reset image
    assert_reset_image_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_bank == RESET_IMAGE && !sda_oe));

    // R3, R5: the bank only moves in the cycle after a write strobe
    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_bank));

    // R6: no strobe is ever aimed at the read-only register
    assert_no_ro_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < IDX_W'(NUM_REGS - 1)));

    // R4: one strobe per received data byte
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R2, R8: an idle slave never pulls SDA low in the following cycle
    assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> !sda_oe);

endmodule

bind cfg_serial_slave cfgs_checker #(
    .NUM_REGS    (NUM_REGS),
    .RESET_IMAGE (RESET_IMAGE)
) u_cfgs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe_o),
    .cfg_bank (cfg_bank_o),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .phase    (phase)
);

// File: tb/test_cfg_serial_slave.sv
// Bench: bit-level bus master, register model, random plus directed transfers.
module test_cfg_serial_slave;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic [63:0] bank;
    wire         sda_bus = ~(m_low | sda_oe);

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] model [8];

    always #4 clk = ~clk;

    cfg_serial_slave i_cfg_serial_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .cfg_bank_o (bank)
    );

    // Reset value of register i, from R9
    function automatic logic [7:0] reset_byte(int i);
        case (i)
            0: return 8'h00;
            3: return 8'h7F;
            6: return 8'h07;
            7: return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [63:0] model_image();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = model[i];
        return v;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 1'b1; m_low = 1'b0; qwait();
        m_low = 1'b1; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        m_low = 1'b0; qwait(); qwait();
    endtask

    // Sends one byte MSB first; nack=1 when SDA was high in the ninth pulse
    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; qwait();
            scl_m = 1'b1; qwait(); qwait();
            scl_m = 1'b0; qwait();
        end
        m_low = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        nack = sda_bus; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            qwait();
            scl_m = 1'b1; qwait();
            b = {b[6:0], sda_bus}; qwait();
            scl_m = 1'b0;
        end
        m_low = ack; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; m_low = 1'b0; qwait();
    endtask

    // Write transfer of n data bytes (R1, R3, R4, R5, R6, R10)
    task automatic wr_txn(input int n, input logic [7:0] d0);
        logic nk;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD2, nk); check("R1 write address ack", 64'(nk), 64'd0);
        send_byte(8'($urandom), nk); check("R3 command ack", 64'(nk), 64'd0);
        send_byte(8'($urandom), nk); check("R3 count ack", 64'(nk), 64'd0);
        for (int i = 0; i < n; i++) begin
            d = (i == 0) ? d0 : 8'($urandom);
            send_byte(d, nk);
            check(i < 7 ? "R4 data ack" : "R6 excess data ack", 64'(nk), 64'd0);
            if (i < 7) model[i] = d;
        end
        bus_stop();
        check("R5 R6 R10 bank after write", bank, model_image());
    endtask

    // Read transfer acknowledging bytes before position stop_at (count is position 0)
    task automatic rd_txn(input int stop_at);
        logic nk;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, nk); check("R1 read address ack", 64'(nk), 64'd0);
        for (int p = 0; p <= 8 && p <= stop_at; p++) begin
            recv_byte(p != stop_at, b);
            if (p == 0) check("R7 byte count", 64'(b), 64'h08);
            else        check("R7 register readback", 64'(b), 64'(model[p-1]));
        end
        if (stop_at <= 8) begin
            qwait();
            check("R8 SDA released after NACK", 64'(sda_oe), 64'd0);
        end
        bus_stop();
        check("R8 SDA released after read", 64'(sda_oe), 64'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic nk;
        void'($urandom(32'h1C0FFEE));
        for (int i = 0; i < 8; i++) model[i] = reset_byte(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset image", bank, model_image());
        check("R9 SDA released", 64'(sda_oe), 64'd0);

        // Reset values read back over the bus
        rd_txn(99);

        // R2: wrong address, then a byte that must be ignored
        bus_start();
        send_byte(8'hA4, nk); check("R2 no ack on wrong address", 64'(nk), 64'd1);
        send_byte(8'h00, nk); check("R2 ignored until next start", 64'(nk), 64'd1);
        bus_stop();
        check("R2 bank unchanged", bank, model_image());

        // R3: header only, no data
        wr_txn(0, 8'h00);
        // R5: partial write, two bytes
        wr_txn(2, 8'h5A);
        // R10: a later short write restarts at register 0
        wr_txn(1, 8'hC3);
        // R6: overlong write past the read-only register
        wr_txn(10, 8'h96);
        rd_txn(99);
        // R8: NACK on the count byte, then a NACK in mid-bank
        rd_txn(0);
        rd_txn(4);

        // Random mix
        for (int k = 0; k < 6; k++) begin
            wr_txn(int'($urandom_range(0, 9)), 8'($urandom));
            rd_txn(int'($urandom_range(1, 9)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule